// File: doc/BRIEF.md
# Coprocessor Array Operation Sequencer

This block sits between a processor and a reconfigurable compute array that runs multi-cycle operations. The processor hands it commands over a valid/ready pair: it can select a configuration, write the two operands, start an operation of a given length, or read back the result. While the block is busy, `cmd_ready` stays low, and the processor stalls by holding its command. The block is busy while it fetches a configuration or while an operation runs.

Configurations are named by a small identifier. A four-entry tagged cache holds recently loaded configuration words. A hit makes the word active at once. A miss raises a fetch request and waits for the supplier's done pulse, which delivers the word. The operation length goes into a down-counter. The array datapath updates its accumulator once per counted cycle, and the result register captures the final value when the counter reaches zero.

Top module: `cpa_sequencer`

## Requirements
- R1: After reset, `cmd_ready`=1, `fetch_req`=0, `rd_valid`=0, `active_cfg`=0, every cache entry is empty, and the result register reads 0.
- R2: A configure command (`cmd_op`=1, identifier in `cmd_data[3:0]`) that misses the cache does the following:
  - It raises `fetch_req` with `fetch_id` set to that identifier and holds both until `fetch_done` is seen.
  - The `fetch_cfg` word present with `fetch_done` becomes `active_cfg` at that edge.
  - `cmd_ready` stays low from acceptance until that edge.
- R3: A configure command that hits the cache raises no fetch. The cached word becomes `active_cfg` on the accepting edge, and `cmd_ready` never drops.
- R4: Misses fill cache slots in round-robin order. Once all four slots are valid, a miss evicts the entry that was inserted earliest.
- R5: Operand writes (`cmd_op`=2 for A, 3 for B; value in `cmd_data`) are accepted in one cycle when the block is idle.
- R6: A start command (`cmd_op`=4, length N in `cmd_data[7:0]`) holds `cmd_ready` low for exactly N cycles after acceptance. N=0 does not stall.
- R7: The array clears its accumulator at start and then applies one step per counted cycle, chosen by `active_cfg[1:0]`:
  - 00: acc+A+B
  - 01: acc+A*B
  - 10: acc^A^B
  - 11: acc+A-B

  Arithmetic wraps modulo 2^16. The result is the accumulator after N steps (0 for N=0).
- R8: A read (`cmd_op`=5) raises `rd_valid` for one cycle, one cycle after acceptance, with the result on `rd_data`. A read issued during an operation waits until the operation completes.
- R9: A configure command issued during an operation is held off. No fetch begins until the operation has completed.
- R10: A `fetch_done` pulse while no fetch is pending is ignored: `active_cfg` keeps its value.
- R11: Operand writes issued during an operation are held off until it completes, so the running operation and its stored result are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Processor presents a command |
| cmd_op | input | 3 | Command code: 1 configure, 2 write A, 3 write B, 4 start, 5 read |
| cmd_data | input | 16 | Identifier, operand or length |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| fetch_req | output | 1 | Configuration fetch pending |
| fetch_id | output | 4 | Identifier being fetched |
| fetch_done | input | 1 | Fetched word is on fetch_cfg |
| fetch_cfg | input | 8 | Fetched configuration word |
| active_cfg | output | 8 | Configuration word driving the array |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Result returned by a read |

## Verification
Operation vectors cover all four step functions with operands chosen to show what separates them:
- wrap-around sums and products;
- odd repetition counts for the exclusive-or mode;
- subtraction that goes negative.

The configure sequence is ordered to produce cold misses, plain hits, an eviction of the oldest slot, and a hit on a slot that survived the eviction. Counting fetches tells hits apart from misses. Stall lengths measured at `cmd_ready` tell a correct counter from one off by a cycle. Directed cases cover:
- reads, configures and operand writes issued during a run;
- a stray fetch-done pulse;
- a zero-length operation.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_CFG  = 3'd1,
      OP_WRA  = 3'd2,
      OP_WRB  = 3'd3,
      OP_RUN  = 3'd4,
      OP_RD   = 3'd5
   } cpa_op_e;

   typedef enum logic [1:0] {
      FN_ADD = 2'd0,
      FN_MAC = 2'd1,
      FN_XOR = 2'd2,
      FN_SUB = 2'd3
   } cpa_fn_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_FETCH = 1'b1
   } cpa_state_e;
endpackage

// File: rtl/cpa_cfg_cache.sv
module cpa_cfg_cache #(
   parameter int ENTRIES = 4,
   parameter int IDW     = 4,
   parameter int CW      = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [IDW-1:0] lk_id,
   output logic           hit,
   output logic [CW-1:0]  hit_cfg,
   input  logic           ins_en,
   input  logic [IDW-1:0] ins_id,
   input  logic [CW-1:0]  ins_cfg
);
   localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] hit_vec;
   logic [IDW-1:0]     tag_q [ENTRIES];
   logic [CW-1:0]      dat_q [ENTRIES];
   logic [PW-1:0]      ptr_q;

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
         assign hit_vec[e] = vld_q[e] && (tag_q[e] == lk_id);
      end
   endgenerate

   assign hit = |hit_vec;

   always_comb begin
      hit_cfg = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (hit_vec[e]) hit_cfg = hit_cfg | dat_q[e];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            tag_q[e] <= '0;
            dat_q[e] <= '0;
         end
      end else if (ins_en) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (ptr_q == PW'(e)) begin
               vld_q[e] <= 1'b1;
               tag_q[e] <= ins_id;
               dat_q[e] <= ins_cfg;
            end
         end
         ptr_q <= (ptr_q == PW'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
      end
   end

   // at most one slot may match any identifier
   p_unique_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/cpa_run_counter.sv
module cpa_run_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign last = (cnt_q == CNT_W'(1));

   p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) && !load |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/cpa_fabric.sv
module cpa_fabric
   import cpa_pkg::*;
#(
   parameter int DW     = 16,
   parameter bit MUL_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  cpa_fn_e       fn,
   input  logic [DW-1:0] opa,
   input  logic [DW-1:0] opb,
   output logic [DW-1:0] acc_nxt
);
   logic [DW-1:0] acc_q;
   logic [DW-1:0] prod;

   generate
      if (MUL_EN) begin : g_mul
         assign prod = opa * opb;
      end else begin : g_nomul
         assign prod = opa & opb;
      end
   endgenerate

   always_comb begin
      unique case (fn)
         FN_ADD:  acc_nxt = acc_q + opa + opb;
         FN_MAC:  acc_nxt = acc_q + prod;
         FN_XOR:  acc_nxt = acc_q ^ opa ^ opb;
         default: acc_nxt = acc_q + opa - opb;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else if (step)  acc_q <= acc_nxt;
   end

   p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clear && !step |=> $stable(acc_q));
endmodule

// File: rtl/cpa_sequencer.sv
module cpa_sequencer
   import cpa_pkg::*;
#(
   parameter int DW      = 16,
   parameter int IDW     = 4,
   parameter int CW      = 8,
   parameter int CNT_W   = 8,
   parameter int ENTRIES = 4,
   parameter bit MUL_EN  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   input  logic [2:0]     cmd_op,
   input  logic [DW-1:0]  cmd_data,
   output logic           cmd_ready,
   output logic           fetch_req,
   output logic [IDW-1:0] fetch_id,
   input  logic           fetch_done,
   input  logic [CW-1:0]  fetch_cfg,
   output logic [CW-1:0]  active_cfg,
   output logic           rd_valid,
   output logic [DW-1:0]  rd_data
);
   generate
      if (DW < CNT_W || DW < IDW || CW < 2 || ENTRIES < 2) begin : g_bad_params
         $error("cpa_sequencer: illegal parameter combination");
      end
   endgenerate

   cpa_state_e     st_q;
   cpa_op_e        op;
   logic           fire, running, last;
   logic           hit, ins_en, run_load;
   logic [CW-1:0]  hit_cfg;
   logic [IDW-1:0] pend_q;
   logic [DW-1:0]  opa_q, opb_q, result_q, acc_nxt;

   assign op        = cpa_op_e'(cmd_op);
   assign cmd_ready = (st_q == ST_IDLE) && !running;
   assign fire      = cmd_valid && cmd_ready;
   assign fetch_req = (st_q == ST_FETCH);
   assign fetch_id  = pend_q;
   assign ins_en    = fetch_req && fetch_done;
   assign run_load  = fire && (op == OP_RUN);

   cpa_cfg_cache #(.ENTRIES(ENTRIES), .IDW(IDW), .CW(CW)) u_cache (
      .clk(clk), .rst_n(rst_n),
      .lk_id(cmd_data[IDW-1:0]), .hit(hit), .hit_cfg(hit_cfg),
      .ins_en(ins_en), .ins_id(pend_q), .ins_cfg(fetch_cfg)
   );

   cpa_run_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(run_load), .load_val(cmd_data[CNT_W-1:0]),
      .busy(running), .last(last)
   );

   cpa_fabric #(.DW(DW), .MUL_EN(MUL_EN)) u_fab (
      .clk(clk), .rst_n(rst_n),
      .clear(run_load), .step(running),
      .fn(cpa_fn_e'(active_cfg[1:0])),
      .opa(opa_q), .opb(opb_q), .acc_nxt(acc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         pend_q     <= '0;
         active_cfg <= '0;
         opa_q      <= '0;
         opb_q      <= '0;
         result_q   <= '0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
      end else begin
         rd_valid <= fire && (op == OP_RD);
         if (fire && (op == OP_RD)) rd_data <= result_q;
         if (fire && (op == OP_WRA)) opa_q <= cmd_data;
         if (fire && (op == OP_WRB)) opb_q <= cmd_data;
         if (run_load && (cmd_data[CNT_W-1:0] == '0)) result_q <= '0;
         else if (last)                                result_q <= acc_nxt;
         unique case (st_q)
            ST_IDLE: if (fire && (op == OP_CFG)) begin
               if (hit) begin
                  active_cfg <= hit_cfg;
               end else begin
                  pend_q <= cmd_data[IDW-1:0];
                  st_q   <= ST_FETCH;
               end
            end
            default: if (fetch_done) begin
               active_cfg <= fetch_cfg;
               st_q       <= ST_IDLE;
            end
         endcase
      end
   end

   p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !fetch_done |=> fetch_req && $stable(fetch_id));
   p_hit_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (op == OP_CFG) && hit |=> !fetch_req && active_cfg == $past(hit_cfg));
   p_cfg_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> !fetch_req);
   p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_req && !(fire && (op == OP_CFG)) |=> $stable(active_cfg));
   p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(cmd_valid));
endmodule

// File: tb/tb_cpa_sequencer.sv
module tb_cpa_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int FETCH_LAT  = 3;
   localparam int NVEC       = 10;
   // {id[43:40], a[39:24], b[23:8], n[7:0]}
   localparam logic [43:0] VEC [NVEC] = '{
      {4'd0, 16'd3,      16'd5,      8'd4},
      {4'd1, 16'h00F0,   16'h0F0F,   8'd3},
      {4'd2, 16'd100,    16'd30,     8'd7},
      {4'd3, 16'hFFF0,   16'h0020,   8'd2},
      {4'd0, 16'h0101,   16'h0100,   8'd2},
      {4'd4, 16'd7,      16'd9,      8'd5},
      {4'd0, 16'd2,      16'd2,      8'd6},
      {4'd2, 16'd1,      16'd5,      8'd3},
      {4'd1, 16'd9,      16'd9,      8'd1},
      {4'd5, 16'h8000,   16'h8000,   8'd2}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [15:0] cmd_data = '0;
   logic        cmd_ready, fetch_req, rd_valid;
   logic [3:0]  fetch_id;
   logic        fetch_done;
   logic [7:0]  fetch_cfg, active_cfg;
   logic [15:0] rd_data;

   logic        resp_done = 1'b0, poke_done = 1'b0;
   logic [7:0]  resp_cfg = '0, poke_cfg = '0;
   int          dly = 0, n_fetch = 0;
   int          n_run = 0, n_fail = 0;
   bit          saw_req;

   assign fetch_done = resp_done | poke_done;
   assign fetch_cfg  = poke_done ? poke_cfg : resp_cfg;

   cpa_sequencer dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .cmd_ready(cmd_ready), .fetch_req(fetch_req),
      .fetch_id(fetch_id), .fetch_done(fetch_done), .fetch_cfg(fetch_cfg),
      .active_cfg(active_cfg), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] cfg_word(input logic [3:0] id);
      return 8'(id * 8'h35 + 8'h11);
   endfunction

   // configuration supplier
   always @(negedge clk) begin
      if (resp_done) begin
         resp_done = 1'b0;
         dly = 0;
      end else if (fetch_req) begin
         dly++;
         if (dly == FETCH_LAT) begin
            resp_done = 1'b1;
            resp_cfg  = cfg_word(fetch_id);
            n_fetch++;
         end
      end
   end

   // independent cache model: 4 slots, round-robin fill
   int mtag [4];
   bit mvld [4];
   int mptr = 0;
   function automatic bit model_miss(input int id);
      for (int i = 0; i < 4; i++) if (mvld[i] && mtag[i] == id) return 1'b0;
      mtag[mptr] = id; mvld[mptr] = 1'b1; mptr = (mptr + 1) % 4;
      return 1'b1;
   endfunction

   function automatic logic [15:0] model_run(input logic [1:0] fn, input logic [15:0] a,
                                             input logic [15:0] b, input int n);
      logic [15:0] acc = '0;
      for (int i = 0; i < n; i++) begin
         case (fn)
            2'd0: acc = acc + a + b;
            2'd1: acc = acc + 16'(a * b);
            2'd2: acc = acc ^ a ^ b;
            default: acc = acc + a - b;
         endcase
      end
      return acc;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [15:0] data, output int waited);
      cmd_op = op; cmd_data = data; cmd_valid = 1'b1; waited = 0; saw_req = 1'b0;
      while (!cmd_ready) begin
         if (fetch_req) saw_req = 1'b1;
         @(negedge clk);
         waited++;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_ready(output int cnt);
      cnt = 0;
      while (!cmd_ready) begin @(negedge clk); cnt++; end
   endtask

   task automatic do_cfg(input logic [3:0] id, input string req);
      int w, st, nb;
      bit miss;
      nb = n_fetch;
      miss = model_miss(int'(id));
      issue(3'd1, {12'd0, id}, w);
      if (miss) begin
         chk({req, " R2 fetch_req raised"}, fetch_req, 1'b1);
         chk({req, " R2 fetch_id"}, fetch_id, id);
      end
      wait_ready(st);
      chk({req, miss ? " R2 miss stall" : " R3 hit no stall"}, st, miss ? FETCH_LAT : 0);
      chk({req, miss ? " R2 one fetch" : " R3 no fetch"}, n_fetch - nb, miss ? 1 : 0);
      chk({req, " R3 active word"}, active_cfg, cfg_word(id));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int w;
      logic [15:0] exp_r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready", cmd_ready, 1'b1);
      chk("R1 fetch_req", fetch_req, 1'b0);
      chk("R1 rd_valid", rd_valid, 1'b0);
      chk("R1 active", active_cfg, 8'h00);
      issue(3'd5, 16'd0, w);
      chk("R1 R8 read after reset valid", rd_valid, 1'b1);
      chk("R1 read after reset data", rd_data, 16'd0);

      for (int v = 0; v < NVEC; v++) begin
         logic [3:0]  id = VEC[v][43:40];
         logic [15:0] a  = VEC[v][39:24];
         logic [15:0] b  = VEC[v][23:8];
         int          n  = int'(VEC[v][7:0]);
         do_cfg(id, "R4 vector");
         issue(3'd2, a, w);
         chk("R5 write A accepted at once", w, 0);
         issue(3'd3, b, w);
         chk("R5 write B accepted at once", w, 0);
         issue(3'd4, 16'(n), w);
         issue(3'd5, 16'd0, w);
         chk("R6 run stall length", w, n);
         chk("R8 rd_valid", rd_valid, 1'b1);
         chk("R7 result", rd_data, model_run(cfg_word(id)[1:0], a, b, n));
         @(negedge clk);
         chk("R8 rd_valid one cycle", rd_valid, 1'b0);
      end

      // R9: configure during a run is held off, no fetch during the run
      issue(3'd4, 16'd5, w);
      do_cfg(4'd9, "R9 cfg after run");
      chk("R9 no fetch while running", saw_req, 1'b0);

      // R11: operand write during a run waits; running result unaffected
      do_cfg(4'd3, "R11 setup");
      issue(3'd2, 16'd10, w);
      issue(3'd3, 16'd1, w);
      issue(3'd4, 16'd4, w);
      issue(3'd2, 16'd100, w);
      chk("R11 write held off", w, 4);
      issue(3'd5, 16'd0, w);
      chk("R11 result unaffected", rd_data, 16'd44);
      issue(3'd4, 16'd1, w);
      issue(3'd5, 16'd0, w);
      chk("R11 held write applied later", rd_data, 16'd101);

      // R6/R7: zero-length run, no stall, result 0
      issue(3'd4, 16'd0, w);
      chk("R6 zero length no stall", cmd_ready, 1'b1);
      issue(3'd5, 16'd0, w);
      chk("R7 zero length result", rd_data, 16'd0);

      // R10: stray fetch_done while idle
      exp_r = {8'd0, active_cfg};
      poke_cfg = 8'hFF; poke_done = 1'b1;
      @(negedge clk);
      poke_done = 1'b0;
      @(negedge clk);
      chk("R10 stray done ignored", active_cfg, exp_r[7:0]);
      chk("R10 no fetch raised", fetch_req, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule